// File: doc/BRIEF.md
# Link Speed Retrain Sequencer

After reset, this block makes one pass to decide whether a serial link that has trained to the lowest data rate should be asked to retrain to a faster one. It samples the training state machine's state code, the supported-speed field from the link capability, and the current-speed field and the training-in-progress bit from the link status. It then either finishes straight away or issues one retrain request and waits for the link to settle.

The retrain request is a pulse on `retrain_pulse`, lasting one clock cycle. After the request the sequencer polls the training bit until it clears. It then polls the link-up condition. Each wait has its own timeout. A poll happens on the first cycle of each wait and then once every `POLL_TICKS` ticks of the external time base `tick`. For example, a 1 µs tick and `POLL_TICKS` = 100 give polls 100 µs apart. A timeout raises a flag that stays set, and the sequencer continues anyway. `done` rises when the pass is over and stays high until the next reset.

Top module: `link_retrain_seq`

## Requirements
- R1: The link counts as up only when the 5-bit state code `ltssm_state` equals 0x0F. Every other code, including 0x1F and 0x0E, counts as down.
- R2: If the link is down when sampled after reset, `done` rises, no retrain pulse is issued, and both timeout flags stay 0.
- R3: If the supported-speed code `max_speed` is 1 (2.5 GT/s) or 0, the sequencer finishes without a retrain pulse.
- R4: A retrain pulse is issued only when the link is up, `max_speed` is greater than 1, and `cur_speed` equals 1 (2.5 GT/s). It is exactly one cycle wide. With any other `cur_speed` the sequencer finishes without a pulse.
- R5: After the pulse, the sequencer waits for `training` to read 0 and then for the link to be up. If both happen before their limits, `done` rises and neither timeout flag is set, even if the link drops for a while during the wait.
- R6: If `training` stays 1, `retrain_timeout` is set once TRAIN_POLLS tick-driven polls have followed the first one (TRAIN_POLLS*POLL_TICKS ticks). The sequencer then moves on to the link-up wait and does not set the flag early.
- R7: If the link is not up after LINK_POLLS tick-driven polls of the link-up wait, `linkup_timeout` is set and `done` rises.
- R8: Polls after the first one advance only on `tick`. While `tick` is held low, neither wait times out and `done` stays 0.
- R9: `done` and both timeout flags stay set until reset. No second retrain pulse is issued, whatever the inputs do.
- R10: While `rst` is high, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe, one cycle wide |
| ltssm_state | input | 5 | State code of the link training state machine |
| max_speed | input | 4 | Supported-speed code from the link capability (1 = 2.5 GT/s) |
| cur_speed | input | 4 | Current-speed code from the link status (1 = 2.5 GT/s) |
| training | input | 1 | Link-training-in-progress bit from the link status |
| retrain_pulse | output | 1 | One-cycle request to retrain the link |
| done | output | 1 | Sequence finished (sticky) |
| retrain_timeout | output | 1 | Training bit did not clear in time (sticky) |
| linkup_timeout | output | 1 | Link did not come back up in time (sticky) |

## Verification
The hardest case to reach from the ports is the one where a wait ends at a timeout boundary with `tick` under control. The bench holds `training` at 1 across the retrain pulse and checks part-way into the wait that no flag has risen yet. It then runs past the limit. A separate scenario holds `tick` low for far longer than any limit, to show that only the time base drives the timeouts, and then releases `tick` so that the timeout does arrive. The link-return path is driven by pulling the state code away from 0x0F during training and restoring it later.

// File: rtl/retrain_pkg.sv
package retrain_pkg;
  localparam int SPEED_W  = 4;
  localparam int LTSSM_W  = 5;
  localparam logic [SPEED_W-1:0] SPEED_2G5 = 4'd1;
  localparam logic [LTSSM_W-1:0] LTSSM_L0  = 5'h0F;

  typedef enum logic [2:0] {
    ST_SAMPLE,
    ST_CHECK,
    ST_KICK,
    ST_WAIT_TRAIN,
    ST_WAIT_LINK,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/link_status_decode.sv
module link_status_decode
  import retrain_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [LTSSM_W-1:0] ltssm_state,
  input  logic [SPEED_W-1:0] max_speed,
  input  logic [SPEED_W-1:0] cur_speed,
  input  logic               training,
  output logic               link_up_q,
  output logic               fast_cap_q,
  output logic               slow_cur_q,
  output logic               training_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      link_up_q  <= 1'b0;
      fast_cap_q <= 1'b0;
      slow_cur_q <= 1'b0;
      training_q <= 1'b0;
    end else begin
      link_up_q  <= (ltssm_state == LTSSM_L0);
      fast_cap_q <= (max_speed > SPEED_2G5);
      slow_cur_q <= (cur_speed == SPEED_2G5);
      training_q <= training;
    end
  end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int POLL_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic poll
);
  localparam int CNT_W = (POLL_TICKS > 1) ? $clog2(POLL_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_TICKS - 1);

  logic [CNT_W-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      poll     <= 1'b0;
    end else if (restart) begin
      tick_cnt <= '0;
      poll     <= 1'b1;
    end else if (tick) begin
      if (tick_cnt == LAST) begin
        tick_cnt <= '0;
        poll     <= 1'b1;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
        poll     <= 1'b0;
      end
    end else begin
      poll <= 1'b0;
    end
  end
endmodule

// File: rtl/retrain_fsm.sv
module retrain_fsm
  import retrain_pkg::*;
#(
  parameter int TRAIN_POLLS = 10000,
  parameter int LINK_POLLS  = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic link_up,
  input  logic fast_cap,
  input  logic slow_cur,
  input  logic training,
  input  logic poll,
  output logic restart,
  output logic retrain_pulse,
  output logic done,
  output logic retrain_timeout,
  output logic linkup_timeout
);
  localparam int MAXP  = (TRAIN_POLLS > LINK_POLLS) ? TRAIN_POLLS : LINK_POLLS;
  localparam int PCW   = $clog2(MAXP + 1);
  localparam logic [PCW-1:0] TR_LIM = PCW'(TRAIN_POLLS);
  localparam logic [PCW-1:0] LK_LIM = PCW'(LINK_POLLS);

  seq_state_t state, state_n;
  logic [PCW-1:0] poll_cnt;

  always_comb begin
    state_n = state;
    restart = 1'b0;
    case (state)
      ST_SAMPLE: state_n = ST_CHECK;
      ST_CHECK: begin
        if (link_up && fast_cap && slow_cur) state_n = ST_KICK;
        else                                 state_n = ST_DONE;
      end
      ST_KICK: begin
        restart = 1'b1;
        state_n = ST_WAIT_TRAIN;
      end
      ST_WAIT_TRAIN: begin
        if (poll && (!training || poll_cnt == TR_LIM)) begin
          restart = 1'b1;
          state_n = ST_WAIT_LINK;
        end
      end
      ST_WAIT_LINK: begin
        if (poll && (link_up || poll_cnt == LK_LIM)) state_n = ST_DONE;
      end
      ST_DONE: state_n = ST_DONE;
      default: state_n = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_SAMPLE;
      poll_cnt        <= '0;
      retrain_pulse   <= 1'b0;
      done            <= 1'b0;
      retrain_timeout <= 1'b0;
      linkup_timeout  <= 1'b0;
    end else begin
      state         <= state_n;
      retrain_pulse <= (state == ST_CHECK) && (state_n == ST_KICK);
      if (state_n == ST_DONE) done <= 1'b1;

      if (state == ST_WAIT_TRAIN && poll && training && poll_cnt == TR_LIM)
        retrain_timeout <= 1'b1;
      if (state == ST_WAIT_LINK && poll && !link_up && poll_cnt == LK_LIM)
        linkup_timeout <= 1'b1;

      if (restart || state_n == ST_DONE) poll_cnt <= '0;
      else if (poll && (state == ST_WAIT_TRAIN || state == ST_WAIT_LINK))
        poll_cnt <= poll_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/link_retrain_seq.sv
module link_retrain_seq
  import retrain_pkg::*;
#(
  parameter int POLL_TICKS  = 100,
  parameter int TRAIN_POLLS = 10000,
  parameter int LINK_POLLS  = 10000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [LTSSM_W-1:0] ltssm_state,
  input  logic [SPEED_W-1:0] max_speed,
  input  logic [SPEED_W-1:0] cur_speed,
  input  logic               training,
  output logic               retrain_pulse,
  output logic               done,
  output logic               retrain_timeout,
  output logic               linkup_timeout
);
  logic link_up_q, fast_cap_q, slow_cur_q, training_q;
  logic restart, poll;

  link_status_decode i_decode (
    .clk        (clk),
    .rst        (rst),
    .ltssm_state(ltssm_state),
    .max_speed  (max_speed),
    .cur_speed  (cur_speed),
    .training   (training),
    .link_up_q  (link_up_q),
    .fast_cap_q (fast_cap_q),
    .slow_cur_q (slow_cur_q),
    .training_q (training_q)
  );

  poll_timer #(.POLL_TICKS(POLL_TICKS)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .tick   (tick),
    .poll   (poll)
  );

  retrain_fsm #(.TRAIN_POLLS(TRAIN_POLLS), .LINK_POLLS(LINK_POLLS)) i_fsm (
    .clk            (clk),
    .rst            (rst),
    .link_up        (link_up_q),
    .fast_cap       (fast_cap_q),
    .slow_cur       (slow_cur_q),
    .training       (training_q),
    .poll           (poll),
    .restart        (restart),
    .retrain_pulse  (retrain_pulse),
    .done           (done),
    .retrain_timeout(retrain_timeout),
    .linkup_timeout (linkup_timeout)
  );
endmodule

// File: rtl/retrain_seq_checker.sv
module retrain_seq_checker (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic retrain_pulse,
  input logic done,
  input logic retrain_timeout,
  input logic linkup_timeout
);
  logic [1:0] pulse_seen;

  always_ff @(posedge clk) begin
    if (rst) pulse_seen <= '0;
    else if (retrain_pulse && pulse_seen != 2'd3) pulse_seen <= pulse_seen + 1'b1;
  end

  // R4: the retrain request lasts exactly one cycle
  a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    retrain_pulse |=> !retrain_pulse);

  // R9: at most one request per reset
  a_r9_single_request: assert property (@(posedge clk) disable iff (rst)
    pulse_seen <= 2'd1);

  // R9: completion is sticky
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R6: retrain timeout flag is sticky
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    retrain_timeout |=> retrain_timeout);

  // R7: link-up timeout flag is sticky
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    linkup_timeout |=> linkup_timeout);

  // R9: no request once finished
  a_r9_no_pulse_when_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !retrain_pulse);

  // R8: a timeout only follows a tick two cycles earlier
  a_r8_timeout_needs_tick: assert property (@(posedge clk) disable iff (rst)
    ($rose(retrain_timeout) || $rose(linkup_timeout)) |-> $past(tick, 2));

  // R10: outputs are clear during reset
  always @(posedge clk) begin
    if ($past(rst))
      a_r10_reset_clear: assert (!retrain_pulse && !done && !retrain_timeout && !linkup_timeout);
  end
endmodule

bind link_retrain_seq retrain_seq_checker i_retrain_chk (
  .clk            (clk),
  .rst            (rst),
  .tick           (tick),
  .retrain_pulse  (retrain_pulse),
  .done           (done),
  .retrain_timeout(retrain_timeout),
  .linkup_timeout (linkup_timeout)
);

// File: tb/test_link_retrain_seq.sv
module test_link_retrain_seq;
  localparam int CLK_PERIOD  = 10;
  localparam int POLL_TICKS  = 4;
  localparam int TRAIN_POLLS = 5;
  localparam int LINK_POLLS  = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic [4:0] ltssm_state = 5'h0F;
  logic [3:0] max_speed = 4'd1;
  logic [3:0] cur_speed = 4'd1;
  logic       training = 1'b0;
  logic       retrain_pulse, done, retrain_timeout, linkup_timeout;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_retrain_seq #(
    .POLL_TICKS(POLL_TICKS), .TRAIN_POLLS(TRAIN_POLLS), .LINK_POLLS(LINK_POLLS)
  ) i_link_retrain_seq (
    .clk(clk), .rst(rst), .tick(tick), .ltssm_state(ltssm_state),
    .max_speed(max_speed), .cur_speed(cur_speed), .training(training),
    .retrain_pulse(retrain_pulse), .done(done),
    .retrain_timeout(retrain_timeout), .linkup_timeout(linkup_timeout)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) pulses <= 0;
    else if (retrain_pulse) pulses <= pulses + 1;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [4:0] st, input logic [3:0] mx,
                       input logic [3:0] cu, input logic tr);
    @(negedge clk);
    rst = 1'b1; tick = 1'b1;
    ltssm_state = st; max_speed = mx; cur_speed = cu; training = tr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim && !done; i++) @(negedge clk);
  endtask

  task automatic wait_pulse(input int lim);
    for (int i = 0; i < lim && pulses == 0; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    start(5'h0F, 4'd2, 4'd1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset outputs", {retrain_pulse, done, retrain_timeout, linkup_timeout}, 0);
  endtask

  task automatic t_link_down(input logic [4:0] st);
    start(st, 4'd3, 4'd1, 1'b0);
    wait_done(50);
    check("R1 R2 done with link down", done, 1);
    check("R2 no pulse when link down", pulses, 0);
    check("R2 no flags", {retrain_timeout, linkup_timeout}, 0);
  endtask

  task automatic t_low_cap(input logic [3:0] mx);
    start(5'h0F, mx, 4'd1, 1'b0);
    wait_done(50);
    check("R3 done at low capability", done, 1);
    check("R3 no pulse at low capability", pulses, 0);
  endtask

  task automatic t_fast_already;
    start(5'h0F, 4'd3, 4'd2, 1'b0);
    wait_done(50);
    check("R4 done when not at lowest speed", done, 1);
    check("R4 no pulse when not at lowest speed", pulses, 0);
  endtask

  task automatic t_good_retrain;
    start(5'h0F, 4'd2, 4'd1, 1'b1);
    wait_pulse(50);
    check("R4 one pulse issued", pulses, 1);
    ltssm_state = 5'h0B;
    repeat (3) @(negedge clk);
    training = 1'b0;
    repeat (6) @(negedge clk);
    check("R5 not done while link down", done, 0);
    ltssm_state = 5'h0F;
    wait_done(200);
    check("R5 done after link returns", done, 1);
    check("R5 no timeout flags", {retrain_timeout, linkup_timeout}, 0);
    check("R4 pulse exactly one cycle", pulses, 1);
  endtask

  task automatic t_train_stuck;
    start(5'h0F, 4'd4, 4'd1, 1'b1);
    wait_pulse(50);
    repeat (10) @(negedge clk);
    check("R6 no early retrain timeout", retrain_timeout, 0);
    wait_done(200);
    check("R6 retrain timeout set", retrain_timeout, 1);
    check("R6 link wait still ran, no linkup timeout", linkup_timeout, 0);
    check("R6 done after timeout", done, 1);
  endtask

  task automatic t_link_lost;
    start(5'h0F, 4'd2, 4'd1, 1'b1);
    wait_pulse(50);
    ltssm_state = 5'h07;
    training = 1'b0;
    wait_done(300);
    check("R7 linkup timeout set", linkup_timeout, 1);
    check("R7 done", done, 1);
    check("R7 no retrain timeout", retrain_timeout, 0);
  endtask

  task automatic t_no_tick;
    start(5'h0F, 4'd2, 4'd1, 1'b1);
    wait_pulse(50);
    tick = 1'b0;
    repeat (300) @(negedge clk);
    check("R8 no timeout without tick", retrain_timeout, 0);
    check("R8 not done without tick", done, 0);
    tick = 1'b1;
    wait_done(300);
    check("R8 timeout once tick resumes", retrain_timeout, 1);
    // R9: inputs changed after completion have no effect
    ltssm_state = 5'h0F; training = 1'b0; cur_speed = 4'd1; max_speed = 4'd3;
    repeat (100) @(negedge clk);
    check("R9 still one pulse", pulses, 1);
    check("R9 done and flag held", {done, retrain_timeout}, 3);
  endtask

  initial begin
    t_reset();
    t_link_down(5'h1F);
    t_link_down(5'h0E);
    t_low_cap(4'd1);
    t_low_cap(4'd0);
    t_fast_already();
    t_good_retrain();
    t_train_stuck();
    t_link_lost();
    t_no_tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule